// File: doc/BRIEF.md
# Prioritized Interrupt Distributor with Per-Core Acknowledge

The block collects level-sensitive request lines from peripherals and routes each one to a single processor core. Every source has its own configuration word, written over a simple write-only register bus. The word holds an enable, an 8-bit urgency value (a smaller number is more urgent) and a destination core number. Each source sits in one of three states: idle, waiting or in service. A source goes from idle to waiting when its line is high and it is enabled. It goes from waiting to in service when its destination core acknowledges it. It leaves service when that core writes its ID to the end-of-service port.

Each core interface holds a mask threshold. It selects the most urgent waiting source aimed at it, with ties going to the lowest ID. It drives a level IRQ while that candidate is more urgent than the mask and more urgent than anything the core already has in service. An acknowledge pulse latches the winner's ID onto the core's ID output on the next edge and puts the winner in service. With no eligible candidate, the latched ID is the all-ones spurious code and nothing changes state. A parameter selects between a linear scan and a balanced tournament tree for the per-core arbiters.

Top module: `intd_top`

## Requirements
- R1: A source whose enable bit (bit 31 of its configuration word) is clear never becomes waiting, whatever its line does, and a waiting source whose enable is cleared returns to idle.
- R2: Among the waiting sources aimed at one core, the one with the numerically smallest urgency value (bits 7:0 of the configuration word) is the one presented and acknowledged.
- R3: When several waiting sources of one core share the smallest urgency value, the lowest source ID wins.
- R4: A source is presented only to the core named by its target field, which starts at bit 16 of its configuration word. Other cores neither raise IRQ for it nor acknowledge it.
- R5: A core raises IRQ only while its candidate's urgency value is strictly below that core's mask (bits 7:0 of the word at the mask address). A value equal to the mask is held back. Masks reset to 0, so nothing is delivered after reset until a mask is written.
- R6: An acknowledge pulse while IRQ is high returns the winner's ID on the core's ID output one edge later. It moves the winner into service, and IRQ drops if nothing else qualifies.
- R7: An acknowledge pulse while IRQ is low returns the all-ones spurious ID and leaves every source in its present state.
- R8: A source in service is not presented again until an end-of-service write carrying its ID arrives from its target core. At that point it becomes waiting again if its line is still high and it is enabled, and idle otherwise.
- R9: While a core has a source in service, only a waiting source with a strictly smaller urgency value than every source in service at that core can raise IRQ. Equal values wait.
- R10: Register addresses put the section select in the top address bit (0 = source configuration, 1 = core mask) and the source or core index in the low bits.
- R11: Inputs are levels: a waiting source whose line drops before it is acknowledged returns to idle and is no longer presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | NUM_IRQ | Level request line per source |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register address: section bit on top, index below |
| cfg_wdata | input | DATA_W | Register write data |
| core_irq | output | NUM_CORES | Level IRQ per core |
| ack_rd | input | NUM_CORES | Acknowledge pulse per core |
| ack_id | output | NUM_CORES*ID_W | Latched acknowledged ID per core, all ones when spurious |
| eoi_we | input | NUM_CORES | End-of-service write strobe per core |
| eoi_id | input | NUM_CORES*ID_W | ID retired by each core's end-of-service write |

## Verification
The directed scenarios cover ties in urgency, a candidate whose value equals the mask, and pre-emption by an equal value against a strictly smaller one. A design that compared with less-or-equal in either place would raise IRQ where the bench expects it low. A design that broke ties toward the higher ID would return the wrong source. One scenario retires a source while its line is still high and then again after the line has dropped. A design that lost or kept state wrongly would either fail to present the source again or present it forever. Spurious acknowledges are issued while a masked source is waiting, and the bench then confirms that the same source is still delivered once the mask is raised. Routing is checked by acknowledging a core-1 source from core 0.

// File: rtl/intd_pkg.sv
package intd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_SERV = 2'd2
   } src_state_e;

   localparam int EN_BIT  = 31;
   localparam int TGT_LSB = 16;
endpackage

// File: rtl/intd_arb.sv
module intd_arb #(
   parameter int N      = 16,
   parameter int PRIO_W = 8,
   parameter int ID_W   = 5,
   parameter bit TREE   = 1'b1
) (
   input  logic [N-1:0]        req_i,
   input  logic [N*PRIO_W-1:0] prio_i,
   output logic                win_v_o,
   output logic [PRIO_W-1:0]   win_prio_o,
   output logic [ID_W-1:0]     win_id_o
);
   localparam int LVLS = $clog2(N);
   localparam int P    = 1 << LVLS;

   if (TREE) begin : g_tree
      logic              nv [1:2*P-1];
      logic [PRIO_W-1:0] np [1:2*P-1];
      logic [ID_W-1:0]   ni [1:2*P-1];

      for (genvar j = 0; j < P; j++) begin : g_leaf
         if (j < N) begin : g_real
            assign nv[P+j] = req_i[j];
            assign np[P+j] = prio_i[j*PRIO_W +: PRIO_W];
            assign ni[P+j] = ID_W'(j);
         end else begin : g_pad
            assign nv[P+j] = 1'b0;
            assign np[P+j] = '1;
            assign ni[P+j] = '1;
         end
      end

      for (genvar k = 1; k < P; k++) begin : g_node
         logic take_left;
         assign take_left = nv[2*k] && (!nv[2*k+1] || (np[2*k] <= np[2*k+1]));
         assign nv[k] = nv[2*k] || nv[2*k+1];
         assign np[k] = take_left ? np[2*k] : np[2*k+1];
         assign ni[k] = take_left ? ni[2*k] : ni[2*k+1];
      end

      assign win_v_o    = nv[1];
      assign win_prio_o = np[1];
      assign win_id_o   = ni[1];
   end else begin : g_linear
      always_comb begin
         win_v_o    = 1'b0;
         win_prio_o = '1;
         win_id_o   = '1;
         for (int j = 0; j < N; j++) begin
            if (req_i[j] && (!win_v_o || (prio_i[j*PRIO_W +: PRIO_W] < win_prio_o))) begin
               win_v_o    = 1'b1;
               win_prio_o = prio_i[j*PRIO_W +: PRIO_W];
               win_id_o   = ID_W'(j);
            end
         end
      end
   end
endmodule

// File: rtl/intd_src.sv
module intd_src
   import intd_pkg::*;
#(
   parameter int IDX       = 0,
   parameter int NUM_CORES = 2,
   parameter int PRIO_W    = 8,
   parameter int ID_W      = 5,
   parameter int CORE_W    = 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        line_i,
   input  logic                        cfg_we_i,
   input  logic                        cfg_en_i,
   input  logic [CORE_W-1:0]           cfg_tgt_i,
   input  logic [PRIO_W-1:0]           cfg_prio_i,
   input  logic                        take_i,
   input  logic [NUM_CORES-1:0]        eoi_we_i,
   input  logic [NUM_CORES*ID_W-1:0]   eoi_id_i,
   output src_state_e                  state_o,
   output logic [PRIO_W-1:0]           prio_o,
   output logic [CORE_W-1:0]           tgt_o
);
   logic       en_q;
   logic       live;
   logic       eoi_hit;
   src_state_e state_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         prio_o <= '1;
         tgt_o  <= '0;
      end else if (cfg_we_i) begin
         en_q   <= cfg_en_i;
         prio_o <= cfg_prio_i;
         tgt_o  <= cfg_tgt_i;
      end
   end

   assign live = line_i && en_q;

   always_comb begin
      eoi_hit = 1'b0;
      for (int c = 0; c < NUM_CORES; c++) begin
         if (eoi_we_i[c] && (eoi_id_i[c*ID_W +: ID_W] == ID_W'(IDX)) &&
             (tgt_o == CORE_W'(c)))
            eoi_hit = 1'b1;
      end
   end

   always_comb begin
      state_d = state_o;
      unique case (state_o)
         ST_IDLE: if (live) state_d = ST_WAIT;
         ST_WAIT: begin
            if (take_i)     state_d = ST_SERV;
            else if (!live) state_d = ST_IDLE;
         end
         ST_SERV: if (eoi_hit) state_d = live ? ST_WAIT : ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_o <= ST_IDLE;
      else        state_o <= state_d;
   end
endmodule

// File: rtl/intd_core.sv
module intd_core #(
   parameter int PRIO_W = 8,
   parameter int ID_W   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mask_we_i,
   input  logic [PRIO_W-1:0] mask_i,
   input  logic              cand_v_i,
   input  logic [PRIO_W-1:0] cand_prio_i,
   input  logic [ID_W-1:0]   cand_id_i,
   input  logic              run_v_i,
   input  logic [PRIO_W-1:0] run_prio_i,
   input  logic              ack_rd_i,
   output logic              irq_o,
   output logic              ack_fire_o,
   output logic [ID_W-1:0]   ack_id_o
);
   logic [PRIO_W-1:0] mask_q;
   logic              below_mask;
   logic              beats_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mask_q <= '0;
      else if (mask_we_i) mask_q <= mask_i;
   end

   assign below_mask = cand_prio_i < mask_q;
   assign beats_run  = !run_v_i || (cand_prio_i < run_prio_i);
   assign irq_o      = cand_v_i && below_mask && beats_run;
   assign ack_fire_o = ack_rd_i && irq_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ack_id_o <= '1;
      else if (ack_fire_o) ack_id_o <= cand_id_i;
      else if (ack_rd_i)   ack_id_o <= '1;
   end
endmodule

// File: rtl/intd_top.sv
module intd_top
   import intd_pkg::*;
#(
   parameter int NUM_IRQ   = 16,
   parameter int NUM_CORES = 2,
   parameter int PRIO_W    = 8,
   parameter int DATA_W    = 32,
   parameter bit ARB_TREE  = 1'b1,
   localparam int ID_W     = $clog2(NUM_IRQ + 1),
   localparam int CORE_W   = $clog2(NUM_CORES),
   localparam int IDX_W    = ($clog2(NUM_IRQ) > CORE_W) ? $clog2(NUM_IRQ) : CORE_W,
   localparam int CFG_AW   = IDX_W + 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_IRQ-1:0]        irq_lines,
   input  logic                      cfg_we,
   input  logic [CFG_AW-1:0]         cfg_addr,
   input  logic [DATA_W-1:0]         cfg_wdata,
   output logic [NUM_CORES-1:0]      core_irq,
   input  logic [NUM_CORES-1:0]      ack_rd,
   output logic [NUM_CORES*ID_W-1:0] ack_id,
   input  logic [NUM_CORES-1:0]      eoi_we,
   input  logic [NUM_CORES*ID_W-1:0] eoi_id
);
   if (NUM_IRQ < 2)                  begin : g_chk_irq  $error("NUM_IRQ must be at least 2");   end
   if (NUM_CORES < 2)                begin : g_chk_core $error("NUM_CORES must be at least 2"); end
   if (DATA_W != 32)                 begin : g_chk_dw   $error("DATA_W must be 32");            end
   if (PRIO_W < 1 || PRIO_W > 16)    begin : g_chk_pw   $error("PRIO_W must be 1..16");         end
   if (TGT_LSB + CORE_W > EN_BIT)    begin : g_chk_tgt  $error("target field overlaps enable"); end

   logic              cfg_sec;
   logic [IDX_W-1:0]  cfg_idx;
   logic              unused_cfg;

   src_state_e          st        [NUM_IRQ];
   logic [CORE_W-1:0]   tgt       [NUM_IRQ];
   logic [NUM_IRQ*PRIO_W-1:0] prio_flat;
   logic [2*NUM_IRQ-1:0]      st_flat;
   logic [NUM_IRQ-1:0]  take;

   logic [NUM_CORES-1:0] ack_fire;
   logic [ID_W-1:0]      win_id [NUM_CORES];

   assign cfg_sec    = cfg_addr[CFG_AW-1];
   assign cfg_idx    = cfg_addr[IDX_W-1:0];
   assign unused_cfg = ^cfg_wdata;

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
      logic [PRIO_W-1:0] prio_w;
      intd_src #(
         .IDX(i), .NUM_CORES(NUM_CORES), .PRIO_W(PRIO_W), .ID_W(ID_W), .CORE_W(CORE_W)
      ) u_src (
         .clk       (clk),
         .rst_n     (rst_n),
         .line_i    (irq_lines[i]),
         .cfg_we_i  (cfg_we && !cfg_sec && (cfg_idx == IDX_W'(i))),
         .cfg_en_i  (cfg_wdata[EN_BIT]),
         .cfg_tgt_i (cfg_wdata[TGT_LSB +: CORE_W]),
         .cfg_prio_i(cfg_wdata[PRIO_W-1:0]),
         .take_i    (take[i]),
         .eoi_we_i  (eoi_we),
         .eoi_id_i  (eoi_id),
         .state_o   (st[i]),
         .prio_o    (prio_w),
         .tgt_o     (tgt[i])
      );
      assign prio_flat[i*PRIO_W +: PRIO_W] = prio_w;
      assign st_flat[2*i +: 2]             = st[i];
   end

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      logic [NUM_IRQ-1:0] req_wait;
      logic [NUM_IRQ-1:0] req_serv;
      logic               cand_v, run_v;
      logic [PRIO_W-1:0]  cand_prio, run_prio;
      logic [ID_W-1:0]    cand_id, run_id;
      logic [ID_W-1:0]    id_q;
      logic               unused_run;

      always_comb begin
         for (int i = 0; i < NUM_IRQ; i++) begin
            req_wait[i] = (st[i] == ST_WAIT) && (tgt[i] == CORE_W'(c));
            req_serv[i] = (st[i] == ST_SERV) && (tgt[i] == CORE_W'(c));
         end
      end

      intd_arb #(.N(NUM_IRQ), .PRIO_W(PRIO_W), .ID_W(ID_W), .TREE(ARB_TREE)) u_pick (
         .req_i     (req_wait),
         .prio_i    (prio_flat),
         .win_v_o   (cand_v),
         .win_prio_o(cand_prio),
         .win_id_o  (cand_id)
      );

      intd_arb #(.N(NUM_IRQ), .PRIO_W(PRIO_W), .ID_W(ID_W), .TREE(ARB_TREE)) u_run (
         .req_i     (req_serv),
         .prio_i    (prio_flat),
         .win_v_o   (run_v),
         .win_prio_o(run_prio),
         .win_id_o  (run_id)
      );
      assign unused_run = ^run_id;

      intd_core #(.PRIO_W(PRIO_W), .ID_W(ID_W)) u_core (
         .clk        (clk),
         .rst_n      (rst_n),
         .mask_we_i  (cfg_we && cfg_sec && (cfg_idx == IDX_W'(c))),
         .mask_i     (cfg_wdata[PRIO_W-1:0]),
         .cand_v_i   (cand_v),
         .cand_prio_i(cand_prio),
         .cand_id_i  (cand_id),
         .run_v_i    (run_v),
         .run_prio_i (run_prio),
         .ack_rd_i   (ack_rd[c]),
         .irq_o      (core_irq[c]),
         .ack_fire_o (ack_fire[c]),
         .ack_id_o   (id_q)
      );
      assign win_id[c]               = cand_id;
      assign ack_id[c*ID_W +: ID_W]  = id_q;
   end

   always_comb begin
      take = '0;
      for (int i = 0; i < NUM_IRQ; i++) begin
         for (int c = 0; c < NUM_CORES; c++) begin
            if (ack_fire[c] && (win_id[c] == ID_W'(i))) take[i] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/intd_chk.sv
module intd_chk #(
   parameter int NUM_IRQ   = 16,
   parameter int NUM_CORES = 2,
   parameter int ID_W      = 5
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [NUM_IRQ-1:0]        irq_lines,
   input logic [NUM_CORES-1:0]      core_irq,
   input logic [NUM_CORES-1:0]      ack_rd,
   input logic [NUM_CORES*ID_W-1:0] ack_id,
   input logic [NUM_CORES-1:0]      eoi_we,
   input logic [2*NUM_IRQ-1:0]      st_flat
);
   for (genvar c = 0; c < NUM_CORES; c++) begin : g_c
      AST_SPURIOUS_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_rd[c] && !core_irq[c]) |=> (ack_id[c*ID_W +: ID_W] == {ID_W{1'b1}})); // R7
      AST_ACK_ID_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_rd[c] && core_irq[c]) |=> (ack_id[c*ID_W +: ID_W] < ID_W'(NUM_IRQ))); // R6
   end

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_i
      AST_WAIT_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
         (st_flat[2*i +: 2] == 2'd1) |-> $past(irq_lines[i])); // R11
      AST_SERV_FROM_ACK: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(st_flat[2*i +: 2] == 2'd2) |-> ($past(st_flat[2*i +: 2] == 2'd1) && $past(|ack_rd))); // R6
      AST_SERV_UNTIL_EOI: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(st_flat[2*i +: 2] == 2'd2) |-> $past(|eoi_we)); // R8
   end
endmodule

bind intd_top intd_chk #(.NUM_IRQ(NUM_IRQ), .NUM_CORES(NUM_CORES), .ID_W(ID_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq_lines(irq_lines),
   .core_irq (core_irq),
   .ack_rd   (ack_rd),
   .ack_id   (ack_id),
   .eoi_we   (eoi_we),
   .st_flat  (st_flat)
);

// File: tb/sim_intd_top.sv
`timescale 1ns/1ps
module sim_intd_top;
   localparam int NI = 16;
   localparam int NC = 2;
   localparam int IW = 5;
   localparam int AW = 5;
   localparam logic [IW-1:0] SPUR = '1;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NI-1:0]  irq_lines = '0;
   logic           cfg_we = 1'b0;
   logic [AW-1:0]  cfg_addr = '0;
   logic [31:0]    cfg_wdata = '0;
   logic [NC-1:0]  core_irq;
   logic [NC-1:0]  ack_rd = '0;
   logic [NC*IW-1:0] ack_id;
   logic [NC-1:0]  eoi_we = '0;
   logic [NC*IW-1:0] eoi_id = '0;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   intd_top u0 (
      .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .core_irq(core_irq),
      .ack_rd(ack_rd), .ack_id(ack_id), .eoi_we(eoi_we), .eoi_id(eoi_id)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // R10: source words at {0,idx}; enable bit 31, target from bit 16, urgency bits 7:0
   task automatic src(input int id, input bit en, input int tgt, input int prio);
      logic [31:0] d;
      d = '0;
      d[31] = en;
      d[16] = tgt[0];
      d[7:0] = prio[7:0];
      wr({1'b0, id[3:0]}, d);
   endtask

   // R10: core masks at {1,core}
   task automatic mask(input int c, input int m);
      wr({1'b1, 3'b0, c[0]}, {24'b0, m[7:0]});
   endtask

   task automatic ack(input int c, output int id);
      @(negedge clk);
      ack_rd[c] = 1'b1;
      @(negedge clk);
      ack_rd = '0;
      id = int'(ack_id[c*IW +: IW]);
   endtask

   task automatic eoi(input int c, input int id);
      @(negedge clk);
      eoi_we[c] = 1'b1;
      eoi_id[c*IW +: IW] = id[IW-1:0];
      @(negedge clk);
      eoi_we = '0;
   endtask

   task automatic settle();
      repeat (2) @(negedge clk);
   endtask

   task automatic line(input int i, input bit v);
      @(negedge clk);
      irq_lines[i] = v;
   endtask

   task automatic clean();
      @(negedge clk);
      irq_lines = '0;
      for (int i = 0; i < NI; i++) src(i, 1'b0, 0, 255);
      settle();
   endtask

   task automatic t_reset();
      int id;
      chk("R5 reset irq", int'(core_irq), 0);
      ack(0, id);
      chk("R7 reset ack", id, int'(SPUR));
   endtask

   task automatic t_enable();
      int id;
      mask(0, 255); mask(1, 255);
      src(3, 1'b0, 0, 16);
      line(3, 1'b1);
      settle();
      chk("R1 disabled no irq", int'(core_irq[0]), 0);
      ack(0, id);
      chk("R1 disabled ack", id, int'(SPUR));
      src(3, 1'b1, 0, 16);
      settle();
      chk("R1 enabled irq", int'(core_irq[0]), 1);
      src(3, 1'b0, 0, 16);
      settle();
      chk("R1 enable cleared", int'(core_irq[0]), 0);
      clean();
   endtask

   task automatic t_prio();
      int id;
      src(5, 1'b1, 0, 8'h40);
      src(9, 1'b1, 0, 8'h20);
      line(5, 1'b1); line(9, 1'b1);
      settle();
      chk("R2 irq", int'(core_irq[0]), 1);
      ack(0, id);
      chk("R2 winner", id, 9);
      chk("R6 irq drops", int'(core_irq[0]), 0);
      ack(0, id);
      chk("R7 spurious in service", id, int'(SPUR));
      eoi(0, 9);
      chk("R8 rewait irq", int'(core_irq[0]), 1);
      ack(0, id);
      chk("R8 rewait id", id, 9);
      line(9, 1'b0);
      eoi(0, 9);
      settle();
      ack(0, id);
      chk("R8 retired next", id, 5);
      eoi(0, 5);
      clean();
   endtask

   task automatic t_tie();
      int id;
      src(12, 1'b1, 0, 8'h30);
      src(4, 1'b1, 0, 8'h30);
      line(12, 1'b1); line(4, 1'b1);
      settle();
      ack(0, id);
      chk("R3 tie low id", id, 4);
      eoi(0, 4);
      clean();
   endtask

   task automatic t_target();
      int id;
      src(6, 1'b1, 1, 8'h10);
      line(6, 1'b1);
      settle();
      chk("R4 core1 irq", int'(core_irq[1]), 1);
      chk("R4 core0 quiet", int'(core_irq[0]), 0);
      ack(0, id);
      chk("R4 core0 ack", id, int'(SPUR));
      ack(1, id);
      chk("R10 core1 ack", id, 6);
      eoi(1, 6);
      clean();
   endtask

   task automatic t_mask();
      int id;
      mask(0, 8'h50);
      src(2, 1'b1, 0, 8'h50);
      line(2, 1'b1);
      settle();
      chk("R5 equal mask held", int'(core_irq[0]), 0);
      ack(0, id);
      chk("R7 masked ack", id, int'(SPUR));
      mask(0, 8'h51);
      settle();
      chk("R5 below mask irq", int'(core_irq[0]), 1);
      ack(0, id);
      chk("R7 state kept", id, 2);
      eoi(0, 2);
      mask(0, 255);
      clean();
   endtask

   task automatic t_preempt();
      int id;
      src(1, 1'b1, 0, 8'h80);
      src(7, 1'b1, 0, 8'h80);
      src(10, 1'b1, 0, 8'h7F);
      line(1, 1'b1);
      settle();
      ack(0, id);
      chk("R9 first", id, 1);
      line(7, 1'b1);
      settle();
      chk("R9 equal waits", int'(core_irq[0]), 0);
      line(10, 1'b1);
      settle();
      chk("R9 stricter preempts", int'(core_irq[0]), 1);
      ack(0, id);
      chk("R9 preempt id", id, 10);
      eoi(0, 10);
      eoi(0, 1);
      clean();
   endtask

   task automatic t_level();
      int id;
      src(11, 1'b1, 0, 8'h10);
      line(11, 1'b1);
      settle();
      chk("R11 raised", int'(core_irq[0]), 1);
      line(11, 1'b0);
      @(negedge clk);
      chk("R11 dropped", int'(core_irq[0]), 0);
      ack(0, id);
      chk("R11 ack spurious", id, int'(SPUR));
      clean();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_enable();
      t_prio();
      t_tie();
      t_target();
      t_mask();
      t_preempt();
      t_level();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule